// File: doc/BRIEF.md
# Kernel-Weighted Point Shift Pipeline

This block performs one mean shift step for a single point in a three-dimensional feature space. The dimensions are column, row and intensity. A start pulse captures the point to be moved and clears the running sums. The pixels of the source image are then streamed past the captured point, at most one per clock and with no back-pressure. For every streamed pixel the block does three things: it forms the squared Euclidean distance to the held point, scales that distance by a bandwidth shift, and converts it to an 8-bit Gaussian-shaped weight through a table that is computed at elaboration.

The weights, and the weighted coordinates, are summed in fixed point. When the pixel marked as last has passed through the pipeline, a private restoring divider forms the weighted mean in each dimension. This mean is the shifted location, and it is reported for one cycle together with a flag that shows whether the move was small enough to count as converged. Several copies of this block can run side by side, each moving its own point, while the same image stream is broadcast to all of them.

Top module: `msh_point_engine`

## Requirements
- R1: A start pulse captures the target coordinates and clears all weighted sums and the weight sum, so a result depends only on the pixels streamed after the most recent start.
- R2: A pixel is taken on every clock on which `pix_valid` is high, with no ready or stall signal; a cycle with `pix_valid` low adds nothing to any sum whatever its coordinates.
- R3: For each pixel the squared distance is d = dx² + dy² + dg², and the table index is d shifted right by `bw_shift`; an index above 255 gives weight zero, otherwise the weight is the table entry at that index.
- R4: The weight table is defined by e(0) = 65535, e(i) = floor(e(i−1) · 63520 / 65536), and entry(i) = floor(e(i) / 256), so that entry(0) = 255.
- R5: When the weight sum is non-zero, each result coordinate equals floor(Σ w·c / Σ w) over the pixels taken in that dimension.
- R6: `res_valid` is a single-cycle pulse. With a non-zero weight sum it rises 12 clock edges after the edge that took the last pixel (3 pipeline and accumulator edges, 8 divider steps and 1 output edge).
- R7: When the weight sum is zero, the held coordinates are returned unchanged and `res_valid` rises 3 edges after the edge that took the last pixel.
- R8: `converged` is high together with a result exactly when the absolute difference between the result and the held coordinate is at or below `conv_thr` in all three dimensions.
- R9: The sums hold 4096 pixels, each with maximum weight and coordinate 255, without overflow; such a stream against a target of (255,255,255) returns (255,255,255).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Captures the target and clears the sums |
| tgt_x | input | 8 | Column of the point being moved |
| tgt_y | input | 8 | Row of the point being moved |
| tgt_g | input | 8 | Intensity of the point being moved |
| bw_shift | input | 5 | Right shift that applies the bandwidth to the squared distance |
| conv_thr | input | 8 | Largest per-dimension shift still reported as converged |
| pix_valid | input | 1 | Streamed pixel is present this cycle |
| pix_last | input | 1 | Marks the final pixel of the stream |
| pix_x | input | 8 | Column of the streamed pixel |
| pix_y | input | 8 | Row of the streamed pixel |
| pix_g | input | 8 | Intensity of the streamed pixel |
| res_valid | output | 1 | One-cycle pulse when a new location is ready |
| res_x | output | 8 | New column |
| res_y | output | 8 | New row |
| res_g | output | 8 | New intensity |
| converged | output | 1 | Every dimension moved no more than `conv_thr` |

## Verification
A result is due 12 clock edges after the last pixel is taken when weight was gathered, and 3 edges after it when the weight sum is zero. The bench drives and samples on falling edges. After the falling edge that follows the last pixel, it counts falling edges until `res_valid` appears, and it compares that count with the due value for the case at hand. It also reads the coordinates and the convergence flag in that same sample, and confirms that the pulse has gone by the next falling edge.

// File: rtl/msh_pkg.sv
package msh_pkg;

    localparam int NDIM      = 3;
    localparam int LUT_N     = 256;
    localparam int LUT_IDX_W = 8;
    localparam int W_W       = 8;
    localparam int DECAY_Q16 = 63520;

    typedef enum logic [1:0] {
        PH_RUN,
        PH_LOAD,
        PH_DIV,
        PH_FIN
    } phase_e;

    // Geometric decay table: e(0)=65535, e(i)=e(i-1)*DECAY/65536, weight=e>>8
    function automatic logic [LUT_N*W_W-1:0] build_lut();
        logic [LUT_N*W_W-1:0] tab;
        longint               e;
        tab = '0;
        e   = 65535;
        for (int i = 0; i < LUT_N; i++) begin
            tab[i*W_W +: W_W] = W_W'(e >> 8);
            e = (e * DECAY_Q16) >> 16;
        end
        return tab;
    endfunction

endpackage

// File: rtl/msh_dist.sv
module msh_dist
    import msh_pkg::*;
#(
    parameter int COORD_W = 8,
    parameter int D_W     = 2*COORD_W + 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic                             in_last,
    input  logic [NDIM-1:0][COORD_W-1:0]     in_pix,
    input  logic [NDIM-1:0][COORD_W-1:0]     ref_pix,
    output logic                             out_valid,
    output logic                             out_last,
    output logic [NDIM-1:0][COORD_W-1:0]     out_pix,
    output logic [D_W-1:0]                   out_dist
);

    logic [NDIM-1:0][COORD_W-1:0] gap;
    logic [NDIM-1:0][D_W-1:0]     sq;
    logic [D_W-1:0]               dist_d;

    for (genvar k = 0; k < NDIM; k++) begin : g_axis
        assign gap[k] = (in_pix[k] >= ref_pix[k]) ? in_pix[k] - ref_pix[k]
                                                  : ref_pix[k] - in_pix[k];
        assign sq[k]  = D_W'(gap[k]) * D_W'(gap[k]);
    end

    always_comb begin
        dist_d = '0;
        for (int k = 0; k < NDIM; k++) dist_d = dist_d + sq[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_pix   <= '0;
            out_dist  <= '0;
        end else begin
            out_valid <= in_valid;
            out_last  <= in_valid & in_last;
            out_pix   <= in_pix;
            out_dist  <= dist_d;
        end
    end

    // R2: every accepted pixel advances one stage on the next edge, never held back
    a_r2_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

endmodule

// File: rtl/msh_kernel.sv
module msh_kernel
    import msh_pkg::*;
#(
    parameter int COORD_W = 8,
    parameter int D_W     = 2*COORD_W + 2,
    parameter int SH_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         in_last,
    input  logic [NDIM-1:0][COORD_W-1:0] in_pix,
    input  logic [D_W-1:0]               in_dist,
    input  logic [SH_W-1:0]              bw_shift,
    output logic                         out_valid,
    output logic                         out_last,
    output logic [NDIM-1:0][COORD_W-1:0] out_pix,
    output logic [W_W-1:0]               out_w
);

    localparam logic [LUT_N*W_W-1:0] KLUT = build_lut();

    logic [D_W-1:0] scaled;
    logic           beyond;
    logic [W_W-1:0] w_d;

    assign scaled = in_dist >> bw_shift;
    assign beyond = (scaled >= D_W'(LUT_N));

    always_comb begin
        if (beyond) w_d = '0;
        else        w_d = KLUT[32'(scaled[LUT_IDX_W-1:0])*W_W +: W_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_pix   <= '0;
            out_w     <= '0;
        end else begin
            out_valid <= in_valid;
            out_last  <= in_valid & in_last;
            out_pix   <= in_pix;
            out_w     <= w_d;
        end
    end

    // R3: a scaled distance past the table end yields no weight
    a_r3_far_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && beyond) |=> (out_valid && out_w == '0));

endmodule

// File: rtl/msh_div.sv
module msh_div #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 20,
    parameter int Q_W   = 8,
    parameter int IDX_W = (Q_W > 1) ? $clog2(Q_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [Q_W-1:0]   quo
);

    localparam int T_W = NUM_W + Q_W;

    logic [NUM_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [Q_W-1:0]   quo_q;
    logic [T_W-1:0]   trial;
    logic             fits;

    assign trial = T_W'(den_q) << bit_idx;
    assign fits  = T_W'(rem_q) >= trial;
    assign quo   = quo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            rem_q <= num;
            den_q <= den;
            quo_q <= '0;
        end else if (step && fits) begin
            rem_q          <= rem_q - trial[NUM_W-1:0];
            quo_q[bit_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/msh_point_engine.sv
module msh_point_engine
    import msh_pkg::*;
#(
    parameter int COORD_W  = 8,
    parameter int SH_W     = 5,
    parameter int MAXPIX_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] tgt_x,
    input  logic [COORD_W-1:0] tgt_y,
    input  logic [COORD_W-1:0] tgt_g,
    input  logic [SH_W-1:0]    bw_shift,
    input  logic [COORD_W-1:0] conv_thr,
    input  logic               pix_valid,
    input  logic               pix_last,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COORD_W-1:0] pix_g,
    output logic               res_valid,
    output logic [COORD_W-1:0] res_x,
    output logic [COORD_W-1:0] res_y,
    output logic [COORD_W-1:0] res_g,
    output logic               converged
);

    localparam int D_W   = 2*COORD_W + 2;
    localparam int ACC_W = COORD_W + W_W + MAXPIX_W;
    localparam int WS_W  = W_W + MAXPIX_W;
    localparam int CNT_W = (COORD_W > 1) ? $clog2(COORD_W) : 1;

    typedef logic [NDIM-1:0][COORD_W-1:0] pt_t;

    typedef struct packed {
        phase_e                     phase;
        logic [CNT_W-1:0]           cnt;
        pt_t                        held;
        logic [NDIM-1:0][ACC_W-1:0] acc;
        logic [WS_W-1:0]            wsum;
        pt_t                        res;
        logic                       res_valid;
        logic                       conv;
    } core_t;

    core_t st_d, st_q;

    pt_t            in_pix, s1_pix, s2_pix, quo;
    logic           s1_valid, s1_last, s2_valid, s2_last;
    logic [D_W-1:0] s1_dist;
    logic [W_W-1:0] s2_w;

    assign in_pix = {pix_g, pix_y, pix_x};

    msh_dist #(.COORD_W(COORD_W), .D_W(D_W)) u_dist (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pix_valid), .in_last(pix_last), .in_pix(in_pix),
        .ref_pix(st_q.held),
        .out_valid(s1_valid), .out_last(s1_last), .out_pix(s1_pix),
        .out_dist(s1_dist)
    );

    msh_kernel #(.COORD_W(COORD_W), .D_W(D_W), .SH_W(SH_W)) u_kernel (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s1_valid), .in_last(s1_last), .in_pix(s1_pix),
        .in_dist(s1_dist), .bw_shift(bw_shift),
        .out_valid(s2_valid), .out_last(s2_last), .out_pix(s2_pix),
        .out_w(s2_w)
    );

    for (genvar k = 0; k < NDIM; k++) begin : g_div
        msh_div #(.NUM_W(ACC_W), .DEN_W(WS_W), .Q_W(COORD_W), .IDX_W(CNT_W)) u_div (
            .clk(clk), .rst_n(rst_n),
            .load(st_q.phase == PH_LOAD),
            .step(st_q.phase == PH_DIV),
            .bit_idx(st_q.cnt),
            .num(st_q.acc[k]),
            .den(st_q.wsum),
            .quo(quo[k])
        );
    end

    function automatic logic near(input logic [COORD_W-1:0] a,
                                  input logic [COORD_W-1:0] b,
                                  input logic [COORD_W-1:0] lim);
        logic [COORD_W-1:0] m;
        m = (a >= b) ? a - b : b - a;
        return m <= lim;
    endfunction

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;

        if (s2_valid) begin
            for (int k = 0; k < NDIM; k++)
                st_d.acc[k] = st_q.acc[k] + ACC_W'(s2_w) * ACC_W'(s2_pix[k]);
            st_d.wsum = st_q.wsum + WS_W'(s2_w);
            if (s2_last) st_d.phase = PH_LOAD;
        end

        case (st_q.phase)
            PH_LOAD: begin
                if (st_q.wsum == '0) begin
                    st_d.res       = st_q.held;
                    st_d.res_valid = 1'b1;
                    st_d.conv      = 1'b1;
                    st_d.phase     = PH_RUN;
                end else begin
                    st_d.cnt   = CNT_W'(COORD_W - 1);
                    st_d.phase = PH_DIV;
                end
            end
            PH_DIV: begin
                if (st_q.cnt == '0) st_d.phase = PH_FIN;
                else                st_d.cnt   = st_q.cnt - 1'b1;
            end
            PH_FIN: begin
                st_d.res       = quo;
                st_d.res_valid = 1'b1;
                st_d.conv      = 1'b1;
                for (int k = 0; k < NDIM; k++)
                    if (!near(quo[k], st_q.held[k], conv_thr)) st_d.conv = 1'b0;
                st_d.phase = PH_RUN;
            end
            default: ;
        endcase

        if (start) begin
            st_d.held  = {tgt_g, tgt_y, tgt_x};
            st_d.acc   = '0;
            st_d.wsum  = '0;
            st_d.phase = PH_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.res_valid;
    assign res_x     = st_q.res[0];
    assign res_y     = st_q.res[1];
    assign res_g     = st_q.res[2];
    assign converged = st_q.conv;

    // R6: a result is announced for exactly one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.res_valid |=> !st_q.res_valid);

    // R7: an empty weight sum returns the held point on the next edge
    a_r7_empty_keeps_point: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_LOAD && st_q.wsum == '0 && !start)
            |=> (st_q.res_valid && st_q.res == $past(st_q.held)));

    // R9: the weight sum never wraps between starts
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (st_q.wsum >= $past(st_q.wsum)));

endmodule

// File: tb/msh_point_engine_bench.sv
`timescale 1ns/1ps
module msh_point_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tgt_x = '0, tgt_y = '0, tgt_g = '0;
    logic [4:0] bw_shift = '0;
    logic [7:0] conv_thr = '0;
    logic       pix_valid = 1'b0, pix_last = 1'b0;
    logic [7:0] pix_x = '0, pix_y = '0, pix_g = '0;
    logic       res_valid, converged;
    logic [7:0] res_x, res_y, res_g;

    always #2.5 clk = ~clk;

    msh_point_engine u_msh_point_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tgt_x(tgt_x), .tgt_y(tgt_y), .tgt_g(tgt_g),
        .bw_shift(bw_shift), .conv_thr(conv_thr),
        .pix_valid(pix_valid), .pix_last(pix_last),
        .pix_x(pix_x), .pix_y(pix_y), .pix_g(pix_g),
        .res_valid(res_valid), .res_x(res_x), .res_y(res_y), .res_g(res_g),
        .converged(converged)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int tbl [0:255];
    int px [0:4095];
    int py [0:4095];
    int pg [0:4095];
    bit pv [0:4095];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Streams n pixels against the given target and checks result, latency, flag, pulse
    task automatic run_case(input string req, input int tx, input int ty, input int tg,
                            input int sh, input int thr, input int n);
        longint sw, ax, ay, ag;
        int ex, ey, eg, elat, lat, ecv;
        sw = 0; ax = 0; ay = 0; ag = 0;
        for (int i = 0; i < n; i++) begin
            if (pv[i]) begin
                longint d, idx;
                int w;
                d   = (px[i]-tx)*(px[i]-tx) + (py[i]-ty)*(py[i]-ty) + (pg[i]-tg)*(pg[i]-tg);
                idx = d >> sh;
                w   = (idx < 256) ? tbl[idx] : 0;
                sw += w; ax += w*px[i]; ay += w*py[i]; ag += w*pg[i];
            end
        end
        if (sw == 0) begin ex = tx; ey = ty; eg = tg; elat = 3; end
        else begin
            ex = int'(ax / sw); ey = int'(ay / sw); eg = int'(ag / sw); elat = 12;
        end
        ecv = (absd(ex,tx) <= thr && absd(ey,ty) <= thr && absd(eg,tg) <= thr) ? 1 : 0;

        @(negedge clk);
        start = 1'b1; tgt_x = 8'(tx); tgt_y = 8'(ty); tgt_g = 8'(tg);
        bw_shift = 5'(sh); conv_thr = 8'(thr);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            pix_valid = pv[i]; pix_last = (i == n-1);
            pix_x = 8'(px[i]); pix_y = 8'(py[i]); pix_g = 8'(pg[i]);
            @(negedge clk);
        end
        pix_valid = 1'b0; pix_last = 1'b0;
        lat = 0;
        while (!res_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        check(lat == elat, req, "R6/R7 latency", lat, elat);
        check(res_x == 8'(ex), req, "res_x", res_x, ex);
        check(res_y == 8'(ey), req, "res_y", res_y, ey);
        check(res_g == 8'(eg), req, "res_g", res_g, eg);
        check(converged == ecv[0], req, "R8 converged", converged, ecv);
        @(negedge clk);
        check(res_valid == 1'b0, req, "R6 single pulse", res_valid, 0);
    endtask

    task automatic fill_same(input int n, input int x, input int y, input int g);
        for (int i = 0; i < n; i++) begin
            px[i] = x; py[i] = y; pg[i] = g; pv[i] = 1'b1;
        end
    endtask

    task automatic t_reset();
        check(res_valid == 1'b0, "R6", "idle res_valid after reset", res_valid, 0);
        check(converged == 1'b0, "R8", "converged after reset", converged, 0);
    endtask

    task automatic t_identity();
        fill_same(8, 37, 200, 90);
        run_case("R5", 37, 200, 90, 0, 0, 8);
    endtask

    task automatic t_mixed_gaps();
        for (int i = 0; i < 40; i++) begin
            int v;
            v = 100 + ((i*7) % 23) - 11; px[i] = v;
            v = 80 + ((i*5) % 19) - 9;   py[i] = v;
            v = 60 + ((i*11) % 29) - 14; pg[i] = v;
            pv[i] = (i % 5 != 3);
            if (!pv[i]) begin px[i] = 250; py[i] = 3; pg[i] = 250; end
        end
        pv[39] = 1'b1;
        run_case("R2", 100, 80, 60, 3, 4, 40);
        run_case("R3", 100, 80, 60, 0, 4, 40);
        run_case("R4", 90, 90, 70, 6, 20, 40);
    endtask

    task automatic t_zero_weight();
        fill_same(6, 200, 200, 200);
        run_case("R7", 0, 0, 0, 0, 0, 6);
    endtask

    task automatic t_converge();
        fill_same(5, 110, 100, 100);
        run_case("R8", 100, 100, 100, 0, 10, 5);
        run_case("R8", 100, 100, 100, 0, 9, 5);
    endtask

    task automatic t_restart();
        fill_same(10, 20, 20, 20);
        run_case("R1", 22, 22, 22, 2, 1, 10);
        for (int i = 0; i < 4; i++) begin
            px[i] = 180 + i; py[i] = 40; pg[i] = 130 - i; pv[i] = 1'b1;
        end
        run_case("R1", 181, 41, 128, 1, 2, 4);
    endtask

    task automatic t_capacity();
        fill_same(4096, 255, 255, 255);
        run_case("R9", 255, 255, 255, 0, 0, 4096);
    endtask

    initial begin
        longint e;
        e = 65535;
        for (int i = 0; i < 256; i++) begin
            tbl[i] = int'(e >> 8);
            e = (e * 63520) >> 16;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_mixed_gaps();
        t_zero_weight();
        t_converge();
        t_restart();
        t_capacity();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule